// File: doc/BRIEF.md
# Threshold-Avoidance Migration Controller

This block is the central decision unit that keeps a group of cores below a thermal limit. Once per management interval it takes a snapshot of every core's predicted temperature, whether the core is currently running a task, and which task that is. It then walks the cores twice. On the first pass it stops tasks on cores whose prediction has reached a proactive stop level, and it places those tasks in a holding queue. On the second pass it hands queued tasks to idle cores whose prediction has fallen to an availability level or below.

The gap between the stop level and the availability level gives hysteresis, so a core that has just been relieved of a task does not receive it back straight away. Every command carries a frequency level. A stop forces the lowest level and a start sets the highest. Commands leave the block one at a time on a valid/ready handshake.

When the interval is finished, the block reports two things. The first is whether it issued any command or still holds queued work, which a downstream balancing stage uses to decide whether it may act. The second is whether the queue is empty. With the default settings the stop level is 39, the availability level is 33, and the absolute limit the stop level protects is 42. The required ordering is limit > stop level > availability level.

Top module: `thermal_guard`

## Requirements
- R1: After reset, cmd_valid_o and done_o are 0, active_o is 0 and queue_empty_o is 1.
- R2: A running core (busy bit 1) whose predicted temperature is greater than or equal to the stop level, equality included, gets one stop command. That command has cmd_start_o = 0, its task field equal to the core's task, and cmd_freq_o = 0 (lowest level).
- R3: A core whose prediction is below the stop level, or which is idle, gets no stop command.
- R4: An idle core whose prediction is less than or equal to the availability level, equality included, receives the oldest queued task. That command has cmd_start_o = 1 and cmd_freq_o = all ones (highest level). An idle core above the availability level receives nothing.
- R5: Within an interval, all stops come before any start. Stops and starts each go out in ascending core index, and queued tasks leave in the order they entered.
- R6: A queued task stays held across intervals until some interval finds an available core for it.
- R7: The queue holds N tasks. A stop that would overflow it is not issued, and the task stays on its core.
- R8: A busy core is never the target of a start, whatever its prediction, and each core receives at most one command per pass.
- R9: While cmd_valid_o is 1 and cmd_ready_i is 0, the command stays valid and its fields stay unchanged. A command counts as transferred only on a cycle where both are 1.
- R10: One cycle after done_o, active_o is 1 if the interval transferred any command or the queue is non-empty, and 0 otherwise. queue_empty_o reflects the queue.
- R11: done_o is a one-cycle pulse at the end of each scan. A pulse on interval_i during a scan is ignored, and input changes during a scan do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| interval_i | input | 1 | Pulse that starts a management interval |
| pred_i | input | N*TEMP_W | Predicted temperature per core, core i at bits [i*TEMP_W +: TEMP_W] |
| busy_i | input | N | Core is running a task |
| task_i | input | N*TASK_W | Task id per core, core i at bits [i*TASK_W +: TASK_W] |
| cmd_ready_i | input | 1 | Receiver accepts the command |
| cmd_valid_o | output | 1 | Command present |
| cmd_core_o | output | IDX_W | Target core index |
| cmd_start_o | output | 1 | 1 = start task, 0 = stop task |
| cmd_task_o | output | TASK_W | Task id |
| cmd_freq_o | output | FREQ_W | Frequency level: 0 lowest, all ones highest |
| active_o | output | 1 | Last interval issued commands or queue still holds work |
| queue_empty_o | output | 1 | Holding queue is empty |
| done_o | output | 1 | Scan finished this cycle |

## Verification
The assertions watch properties that must hold on every cycle. They check that a stalled command holds its fields, and that a start never appears while the queue is empty. They also check that no start is followed by a stop within the same scan, that the queue is never pushed while full, and that the done pulse lasts one cycle. Other behaviour depends on the temperatures fed in, so only the bench's scenarios can show it. This covers the inclusive comparisons at exactly the stop and availability levels, and the handing of tasks to the right cores in queue order. It also covers tasks held across intervals, stops suppressed by a full queue, and the value of the activity flag after each interval.

// File: rtl/tg_pkg.sv
package tg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STOP   = 2'd1,
    ST_ASSIGN = 2'd2,
    ST_FIN    = 2'd3
  } tg_state_e;
endpackage

// File: rtl/tg_level_cmp.sv
module tg_level_cmp #(
  parameter int TEMP_W = 8,
  parameter int STOP_LVL = 39,
  parameter int AVAIL_LVL = 33
) (
  input  logic [TEMP_W-1:0] pred_i,
  input  logic              busy_i,
  output logic              stop_o,
  output logic              start_ok_o
);
  localparam logic [TEMP_W-1:0] StopL  = TEMP_W'(STOP_LVL);
  localparam logic [TEMP_W-1:0] AvailL = TEMP_W'(AVAIL_LVL);

  assign stop_o     = busy_i && (pred_i >= StopL);
  assign start_ok_o = !busy_i && (pred_i <= AvailL);
endmodule

// File: rtl/tg_fifo.sv
module tg_fifo #(
  parameter int DEPTH = 4,
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign dout_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import tg_pkg::*;
#(
  parameter int N = 4,
  parameter int TEMP_W = 8,
  parameter int TASK_W = 4,
  parameter int FREQ_W = 2,
  parameter int STOP_LVL = 39,
  parameter int AVAIL_LVL = 33,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                interval_i,
  input  logic [N*TEMP_W-1:0] pred_i,
  input  logic [N-1:0]        busy_i,
  input  logic [N*TASK_W-1:0] task_i,
  input  logic                cmd_ready_i,
  output logic                cmd_valid_o,
  output logic [IDX_W-1:0]    cmd_core_o,
  output logic                cmd_start_o,
  output logic [TASK_W-1:0]   cmd_task_o,
  output logic [FREQ_W-1:0]   cmd_freq_o,
  output logic                active_o,
  output logic                queue_empty_o,
  output logic                done_o
);
  localparam logic [FREQ_W-1:0] FreqMin = '0;
  localparam logic [FREQ_W-1:0] FreqMax = '1;
  localparam logic [IDX_W-1:0]  LastIdx = IDX_W'(N - 1);

  tg_state_e           state_q;
  logic [IDX_W-1:0]    idx_q;
  logic [N*TEMP_W-1:0] pred_q;
  logic [N-1:0]        busy_q;
  logic [N*TASK_W-1:0] task_q;
  logic                issued_q, active_q;

  logic [N-1:0]      stop_req, start_ok;
  logic              q_push, q_pop, q_empty, q_full;
  logic [TASK_W-1:0] q_head, cur_task;
  logic              in_stop, in_assign, want, fire, advance, last;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    tg_level_cmp #(
      .TEMP_W   (TEMP_W),
      .STOP_LVL (STOP_LVL),
      .AVAIL_LVL(AVAIL_LVL)
    ) u_cmp (
      .pred_i    (pred_q[g*TEMP_W +: TEMP_W]),
      .busy_i    (busy_q[g]),
      .stop_o    (stop_req[g]),
      .start_ok_o(start_ok[g])
    );
  end

  tg_fifo #(.DEPTH(N), .W(TASK_W)) u_queue (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (q_push),
    .pop_i  (q_pop),
    .din_i  (cur_task),
    .dout_o (q_head),
    .empty_o(q_empty),
    .full_o (q_full)
  );

  assign in_stop   = (state_q == ST_STOP);
  assign in_assign = (state_q == ST_ASSIGN);
  assign cur_task  = task_q[idx_q*TASK_W +: TASK_W];
  // full queue suppresses stops; empty queue suppresses starts
  assign want      = (in_stop && stop_req[idx_q] && !q_full) ||
                     (in_assign && start_ok[idx_q] && !q_empty);
  assign fire      = want && cmd_ready_i;
  assign q_push    = in_stop && fire;
  assign q_pop     = in_assign && fire;
  assign advance   = (in_stop || in_assign) && (!want || cmd_ready_i);
  assign last      = (idx_q == LastIdx);

  assign cmd_valid_o   = want;
  assign cmd_core_o    = idx_q;
  assign cmd_start_o   = in_assign;
  assign cmd_task_o    = in_assign ? q_head : cur_task;
  assign cmd_freq_o    = in_assign ? FreqMax : FreqMin;
  assign done_o        = (state_q == ST_FIN);
  assign active_o      = active_q;
  assign queue_empty_o = q_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      pred_q   <= '0;
      busy_q   <= '0;
      task_q   <= '0;
      issued_q <= 1'b0;
      active_q <= 1'b0;
    end else begin
      if (fire) issued_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (interval_i) begin
          pred_q   <= pred_i;
          busy_q   <= busy_i;
          task_q   <= task_i;
          idx_q    <= '0;
          issued_q <= 1'b0;
          state_q  <= ST_STOP;
        end
        ST_STOP: if (advance) begin
          idx_q <= last ? '0 : idx_q + 1'b1;
          if (last) state_q <= ST_ASSIGN;
        end
        ST_ASSIGN: if (advance) begin
          if (last) state_q <= ST_FIN;
          else      idx_q   <= idx_q + 1'b1;
        end
        ST_FIN: begin
          active_q <= issued_q || !q_empty;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/thermal_guard_chk.sv
module thermal_guard_chk #(
  parameter int IDX_W = 2,
  parameter int TASK_W = 4,
  parameter int FREQ_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic [IDX_W-1:0]  cmd_core_o,
  input logic              cmd_start_o,
  input logic [TASK_W-1:0] cmd_task_o,
  input logic [FREQ_W-1:0] cmd_freq_o,
  input logic              queue_empty_o,
  input logic              done_o,
  input logic              q_push,
  input logic              q_full
);
  logic seen_start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_start_q <= 1'b0;
    else if (done_o) seen_start_q <= 1'b0;
    else if (cmd_valid_o && cmd_ready_i && cmd_start_o) seen_start_q <= 1'b1;
  end

  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_core_o) &&
      $stable(cmd_start_o) && $stable(cmd_task_o) && $stable(cmd_freq_o));

  // R4
  start_needs_task_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_start_o |-> !queue_empty_o);

  // R5
  stops_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && seen_start_q |-> cmd_start_o);

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_full |-> !q_push);

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !cmd_valid_o);
endmodule

bind thermal_guard thermal_guard_chk #(
  .IDX_W (IDX_W),
  .TASK_W(TASK_W),
  .FREQ_W(FREQ_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_o  (cmd_valid_o),
  .cmd_ready_i  (cmd_ready_i),
  .cmd_core_o   (cmd_core_o),
  .cmd_start_o  (cmd_start_o),
  .cmd_task_o   (cmd_task_o),
  .cmd_freq_o   (cmd_freq_o),
  .queue_empty_o(queue_empty_o),
  .done_o       (done_o),
  .q_push       (q_push),
  .q_full       (q_full)
);

// File: tb/thermal_guard_tb.sv
`timescale 1ns/1ps
module thermal_guard_tb;
  localparam int N = 4, TEMP_W = 8, TASK_W = 4, FREQ_W = 2, IDX_W = 2;

  logic clk = 1'b0, rst_ni = 1'b0, interval_i = 1'b0, cmd_ready_i = 1'b1;
  logic [N*TEMP_W-1:0] pred_i = '0;
  logic [N-1:0]        busy_i = '0;
  logic [N*TASK_W-1:0] task_i = '0;
  logic                cmd_valid_o, cmd_start_o, active_o, queue_empty_o, done_o;
  logic [IDX_W-1:0]    cmd_core_o;
  logic [TASK_W-1:0]   cmd_task_o;
  logic [FREQ_W-1:0]   cmd_freq_o;

  int checks = 0, errors = 0, cycles = 0;
  int exp_n;
  int exp_core[16], exp_start[16], exp_task[16];
  int got_n;
  int got_core[16], got_start[16], got_task[16], got_freq[16];

  always #2 clk = ~clk;

  thermal_guard u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .interval_i(interval_i), .pred_i(pred_i),
    .busy_i(busy_i), .task_i(task_i), .cmd_ready_i(cmd_ready_i),
    .cmd_valid_o(cmd_valid_o), .cmd_core_o(cmd_core_o), .cmd_start_o(cmd_start_o),
    .cmd_task_o(cmd_task_o), .cmd_freq_o(cmd_freq_o), .active_o(active_o),
    .queue_empty_o(queue_empty_o), .done_o(done_o)
  );

  task automatic final_report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog: act %0d cycles exp < 20000", cycles);
      final_report();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act %0d exp %0d", req, what, act, exp);
    end
  endtask

  task automatic set_core(input int i, input int p, input bit b, input int t);
    pred_i[i*TEMP_W +: TEMP_W] = TEMP_W'(p);
    busy_i[i] = b;
    task_i[i*TASK_W +: TASK_W] = TASK_W'(t);
  endtask

  task automatic expect_cmd(input int c, input int s, input int t);
    exp_core[exp_n] = c; exp_start[exp_n] = s; exp_task[exp_n] = t;
    exp_n++;
  endtask

  // run one interval, collect commands, compare; stall: toggled ready, mid: extra pulse
  task automatic run_interval(input string req, input bit stall, input bit mid,
                              input bit exp_active, input bit exp_qempty);
    int dones = 0;
    bit held = 0;
    int h_core = 0, h_start = 0, h_task = 0, h_freq = 0;
    got_n = 0;
    @(negedge clk); interval_i = 1'b1;
    @(negedge clk); interval_i = 1'b0;
    for (int cyc = 0; cyc < 200; cyc++) begin
      cmd_ready_i = stall ? cyc[0] : 1'b1;
      if (mid && cyc == 2) begin
        interval_i = 1'b1;
        for (int i = 0; i < N; i++) set_core(i, 99, 1'b1, 15);
      end
      if (mid && cyc == 3) interval_i = 1'b0;
      #1;
      if (held) begin
        chk(cmd_valid_o && int'(cmd_core_o) == h_core && int'(cmd_start_o) == h_start &&
            int'(cmd_task_o) == h_task && int'(cmd_freq_o) == h_freq,
            "R9", "stalled command changed (task)", int'(cmd_task_o), h_task);
        held = 0;
      end
      if (cmd_valid_o && !cmd_ready_i) begin
        held = 1;
        h_core = int'(cmd_core_o); h_start = int'(cmd_start_o);
        h_task = int'(cmd_task_o); h_freq = int'(cmd_freq_o);
      end
      if (cmd_valid_o && cmd_ready_i && got_n < 16) begin
        got_core[got_n] = int'(cmd_core_o); got_start[got_n] = int'(cmd_start_o);
        got_task[got_n] = int'(cmd_task_o); got_freq[got_n] = int'(cmd_freq_o);
        got_n++;
      end
      if (done_o) begin dones++; break; end
      @(negedge clk);
    end
    cmd_ready_i = 1'b1;
    chk(dones == 1, "R11", "done pulse seen", dones, 1);
    chk(got_n == exp_n, req, "command count", got_n, exp_n);
    for (int k = 0; k < exp_n && k < got_n; k++) begin
      chk(got_core[k] == exp_core[k], req, "command core", got_core[k], exp_core[k]);
      chk(got_start[k] == exp_start[k], req, "command kind", got_start[k], exp_start[k]);
      chk(got_task[k] == exp_task[k], req, "command task", got_task[k], exp_task[k]);
      chk(got_freq[k] == (exp_start[k] != 0 ? 3 : 0),
          exp_start[k] != 0 ? "R4" : "R2", "freq level",
          got_freq[k], exp_start[k] != 0 ? 3 : 0);
    end
    @(negedge clk); #1;
    chk(active_o == exp_active, "R10", "active flag", int'(active_o), int'(exp_active));
    chk(queue_empty_o == exp_qempty, "R10", "queue empty", int'(queue_empty_o),
        int'(exp_qempty));
    dones = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      if (done_o || cmd_valid_o) dones++;
    end
    chk(dones == 0, "R11", "activity after scan", dones, 0);
    exp_n = 0;
  endtask

  task automatic t_reset();
    #1;
    chk(!cmd_valid_o && !done_o, "R1", "valid/done at reset",
        int'(cmd_valid_o) + int'(done_o), 0);
    chk(!active_o, "R1", "active at reset", int'(active_o), 0);
    chk(queue_empty_o, "R1", "queue empty at reset", int'(queue_empty_o), 1);
  endtask

  // R2 R3: stop at equality, no stop below level
  task automatic t_stop_levels();
    set_core(0, 39, 1, 3); set_core(1, 38, 1, 5);
    set_core(2, 50, 1, 7); set_core(3, 20, 1, 9);
    expect_cmd(0, 0, 3); expect_cmd(2, 0, 7);
    run_interval("R2", 0, 0, 1, 0);
  endtask

  // R4 R6: queued tasks go to cool idle cores in order
  task automatic t_assign();
    set_core(0, 33, 0, 0); set_core(1, 38, 1, 5);
    set_core(2, 34, 0, 0); set_core(3, 10, 0, 0);
    expect_cmd(0, 1, 3); expect_cmd(3, 1, 7);
    run_interval("R4", 0, 0, 1, 1);
  endtask

  task automatic t_quiet();
    for (int i = 0; i < N; i++) set_core(i, 30, 1, i);
    run_interval("R3", 0, 0, 0, 1);
  endtask

  // R5 R9 R11: stops then starts, stalled handshake, ignored mid-scan pulse
  task automatic t_mixed_stall();
    set_core(0, 5, 0, 0); set_core(1, 45, 1, 10);
    set_core(2, 30, 0, 0); set_core(3, 40, 1, 11);
    expect_cmd(1, 0, 10); expect_cmd(3, 0, 11);
    expect_cmd(0, 1, 10); expect_cmd(2, 1, 11);
    run_interval("R5", 1, 1, 1, 1);
  endtask

  // R7 R8 R6: fill queue, suppressed stops, drain around a busy core
  task automatic t_overflow();
    for (int i = 0; i < N; i++) set_core(i, 60, 1, i + 1);
    for (int i = 0; i < N; i++) expect_cmd(i, 0, i + 1);
    run_interval("R7", 0, 0, 1, 0);
    for (int i = 0; i < N; i++) set_core(i, 60, 1, i + 5);
    run_interval("R7", 0, 0, 1, 0);
    set_core(0, 0, 0, 0); set_core(1, 0, 1, 6);
    set_core(2, 0, 0, 0); set_core(3, 0, 0, 0);
    expect_cmd(0, 1, 1); expect_cmd(2, 1, 2); expect_cmd(3, 1, 3);
    run_interval("R8", 0, 0, 1, 0);
    for (int i = 0; i < N; i++) set_core(i, 33, 0, 0);
    expect_cmd(0, 1, 4);
    run_interval("R6", 0, 0, 1, 1);
  endtask

  initial begin
    exp_n = 0;
    t_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_stop_levels();
    t_assign();
    t_quiet();
    t_mixed_stall();
    t_overflow();
    final_report();
  end
endmodule